// File: doc/BRIEF.md
# Footprint-Aware Cache-Address Translation Buffer

This block is a small, fully associative translation buffer for a page-granular DRAM cache that runs without tags. An entry does not map a virtual page to a main-memory physical address. It maps the page to the location of its block inside the DRAM cache. Each entry also keeps two 8-bit footprint vectors, one bit per 64-byte segment. The valid vector shows which segments are present in the cache. The reference vector shows which segments were brought in on demand since the entry was installed.

A lookup goes through two tests. The first test resolves the virtual page. The second test checks the valid bit of the addressed segment. If both pass, the block returns a cache address. If the page is resident but the segment is not, the block issues a segment-fill request and records that fill as outstanding. If the page is absent, the block hands the page number to an external walker through a request/acknowledge handshake. The walker then installs the entry in a round-robin victim slot. The old contents of that slot are presented for write-back to the page table. A broadcast from another buffer may set valid bits at any time. Reference bits are never shared in this way.

The controller has four states:
- IDLE: ready for a lookup.
- RESOLVE: compares the captured request against the entries.
- WALK: waits for the walker.
- STALL: waits until the outstanding fill retires.

The transitions are:
- accept: IDLE to RESOLVE.
- serve: RESOLVE to IDLE, on a hit or after issuing a fill.
- miss: RESOLVE to WALK.
- park: RESOLVE to STALL.
- install: WALK to RESOLVE, on walker acknowledge.
- retry: STALL to RESOLVE, once no fill is outstanding.

Top module: `fp_xlate_buf`

## Requirements
- R1: After reset, `lk_ready` is 1 and `hit_valid`, `fill_req`, `walk_req` and `evict_valid` are 0. All entries are empty, so the first lookup of any page misses.
- R2: A lookup is accepted on a clock edge where `lk_valid` and `lk_ready` are both 1. `lk_ready` is then 0 until the lookup has produced its result. `lk_ready` is 1 again on the cycle after the result.
- R3: The request fields come from `lk_line`: the page number is `lk_line[25:3]` and the segment index is `lk_line[2:0]`. The cycle after acceptance, a resident page whose segment valid bit is set gives `hit_valid`=1 for one cycle. In that cycle `hit_addr` = {entry cache address, segment index}.
- R4: A resident page whose segment valid bit is clear, with no fill outstanding, gives `fill_req`=1 for one cycle. In that cycle `fill_addr` = {entry cache address, segment index}. The lookup then completes. `hit_valid`, `fill_req` and `walk_req` are never high together.
- R5: A `fill_done` pulse while a fill is outstanding sets both the valid bit and the reference bit of the recorded segment. A later lookup of that segment hits.
- R6: While a fill is outstanding, a lookup that would need a fill or a walk raises no `fill_req` and no `walk_req`. It holds `lk_ready` at 0 until the cycle after the fill retires, and is then resolved again.
- R7: With no fill outstanding, a page miss raises `walk_req` one cycle after resolution, with `walk_vpn` = page number. Both hold until `walk_ack`. On `walk_ack` the entry is written with `walk_ca` and `walk_vvec`, and its reference vector is set to zero. The request is resolved again on the next cycle.
- R8: Victim slots are used in order 0, 1, …, ENTRIES-1 and then wrap. If the victim holds a page, `evict_valid`=1 in the cycle of `walk_ack`, with that page's number, valid vector and reference vector. At all other times `evict_valid` is 0.
- R9: A `coh_set` pulse sets valid bit `coh_seg` of the entry whose page equals `coh_vpn`. If no entry holds that page, the pulse has no effect.
- R10: Coherence pulses never change reference bits. A segment made valid only by `coh_set` shows a 0 in the reference vector at eviction.
- R11: A `walk_ack` outside the walk wait, and a `fill_done` with no fill outstanding, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_line | input | 26 | Line address: page number over segment index |
| lk_ready | output | 1 | Block can accept a lookup |
| hit_valid | output | 1 | Lookup hit a valid segment |
| hit_addr | output | 19 | Cache address and segment of the hit |
| fill_req | output | 1 | Segment fill request |
| fill_addr | output | 19 | Cache address and segment to fill |
| fill_done | input | 1 | Outstanding fill has completed |
| walk_req | output | 1 | Page miss, walker needed |
| walk_vpn | output | 23 | Page number for the walker |
| walk_ack | input | 1 | Walker returns an entry |
| walk_ca | input | 16 | Cache address of the returned page |
| walk_vvec | input | 8 | Valid vector of the returned page |
| coh_set | input | 1 | Broadcast: set one valid bit |
| coh_vpn | input | 23 | Page number of the broadcast |
| coh_seg | input | 3 | Segment of the broadcast |
| evict_valid | output | 1 | Victim vectors for page-table write-back |
| evict_vpn | output | 23 | Page number of the victim |
| evict_vvec | output | 8 | Valid vector of the victim |
| evict_rvec | output | 8 | Reference vector of the victim |

## Verification
The bench first fills the buffer with pages. It then forces evictions, so the fifth and sixth installs replace slots 0 and 1. A design with a wrong victim pointer, or with eviction vectors taken after the new install, would report the wrong page number or the wrong vectors.

Two stall cases are run:
- a repeat lookup to the same unfilled segment;
- a page miss issued while a fill is outstanding.

A design that misses either case would raise a second `fill_req` or launch a walk early.

Coherence is checked in three ways:
- a broadcast to a resident page must turn the next lookup into a hit;
- a broadcast to an absent page must leave a later lookup as a fill;
- the evicted reference vector must not show the broadcast segment, which catches a design that merges coherence into the reference bits.

Stray `walk_ack` and `fill_done` pulses are sent while the block is idle. A design that acts on them would install an entry, or mark a segment as present.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

    // Controller states of the lookup engine
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RESOLVE = 2'd1,
        ST_WALK    = 2'd2,
        ST_STALL   = 2'd3
    } fpx_state_e;

endpackage

// File: rtl/fpx_cam.sv
// Parallel key comparison over all entries; returns hit flag and encoded index.
module fpx_cam #(
    parameter int N     = 4,
    parameter int KEY_W = 23,
    parameter int IDX_W = 2
) (
    input  logic             valid [N],
    input  logic [KEY_W-1:0] keys  [N],
    input  logic [KEY_W-1:0] key,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);

    logic [N-1:0] match;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = valid[g] && (keys[g] == key);
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

    assign hit = |match;

endmodule

// File: rtl/fpx_rr.sv
// Round-robin victim pointer, advances once per install.
module fpx_rr #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [IDX_W-1:0] victim
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            victim <= '0;
        end else if (adv) begin
            victim <= (victim == IDX_W'(N - 1)) ? '0 : victim + 1'b1;
        end
    end

endmodule

// File: rtl/fpx_store.sv
// Entry storage: page tag, cache address, valid and reference footprints.
module fpx_store #(
    parameter int N     = 4,
    parameter int IDX_W = 2,
    parameter int VPN_W = 23,
    parameter int CA_W  = 16,
    parameter int SEGS  = 8,
    parameter int SEG_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_en,
    input  logic [IDX_W-1:0] ins_idx,
    input  logic [VPN_W-1:0] ins_vpn,
    input  logic [CA_W-1:0]  ins_ca,
    input  logic [SEGS-1:0]  ins_vvec,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [SEG_W-1:0] fill_seg,
    input  logic             coh_en,
    input  logic [IDX_W-1:0] coh_idx,
    input  logic [SEG_W-1:0] coh_seg,
    output logic             e_valid [N],
    output logic [VPN_W-1:0] e_vpn   [N],
    output logic [CA_W-1:0]  e_ca    [N],
    output logic [SEGS-1:0]  e_vvec  [N],
    output logic [SEGS-1:0]  e_rvec  [N]
);

    logic [SEGS-1:0] fill_mask;
    logic [SEGS-1:0] coh_mask;

    assign fill_mask = SEGS'(1) << fill_seg;
    assign coh_mask  = SEGS'(1) << coh_seg;

    for (genvar g = 0; g < N; g++) begin : g_ent
        logic f_here;
        logic c_here;

        assign f_here = fill_en && (fill_idx == IDX_W'(g));
        assign c_here = coh_en  && (coh_idx  == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                e_valid[g] <= 1'b0;
                e_vpn[g]   <= '0;
                e_ca[g]    <= '0;
                e_vvec[g]  <= '0;
                e_rvec[g]  <= '0;
            end else if (ins_en && (ins_idx == IDX_W'(g))) begin
                e_valid[g] <= 1'b1;
                e_vpn[g]   <= ins_vpn;
                e_ca[g]    <= ins_ca;
                e_vvec[g]  <= ins_vvec;
                e_rvec[g]  <= '0;
            end else begin
                e_vvec[g] <= e_vvec[g] | (f_here ? fill_mask : '0)
                                       | (c_here ? coh_mask  : '0);
                e_rvec[g] <= e_rvec[g] | (f_here ? fill_mask : '0);
            end
        end
    end

endmodule

// File: rtl/fp_xlate_buf.sv
// Footprint-aware translation buffer returning DRAM-cache addresses.
module fp_xlate_buf
    import fpx_pkg::*;
#(
    parameter  int ENTRIES = 4,
    parameter  int VA_W    = 32,
    parameter  int LINE_W  = 6,
    parameter  int SEGS    = 8,
    parameter  int CA_W    = 16,
    localparam int SEG_W   = $clog2(SEGS),
    localparam int VPN_W   = VA_W - LINE_W - SEG_W,
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lk_valid,
    input  logic [VA_W-LINE_W-1:0]  lk_line,
    output logic                    lk_ready,
    output logic                    hit_valid,
    output logic [CA_W+SEG_W-1:0]   hit_addr,
    output logic                    fill_req,
    output logic [CA_W+SEG_W-1:0]   fill_addr,
    input  logic                    fill_done,
    output logic                    walk_req,
    output logic [VPN_W-1:0]        walk_vpn,
    input  logic                    walk_ack,
    input  logic [CA_W-1:0]         walk_ca,
    input  logic [SEGS-1:0]         walk_vvec,
    input  logic                    coh_set,
    input  logic [VPN_W-1:0]        coh_vpn,
    input  logic [SEG_W-1:0]        coh_seg,
    output logic                    evict_valid,
    output logic [VPN_W-1:0]        evict_vpn,
    output logic [SEGS-1:0]         evict_vvec,
    output logic [SEGS-1:0]         evict_rvec
);

    fpx_state_e       state_q, state_d;

    logic [VPN_W-1:0] req_vpn_q;
    logic [SEG_W-1:0] req_seg_q;

    logic             pend_q;
    logic [IDX_W-1:0] pend_idx_q;
    logic [SEG_W-1:0] pend_seg_q;

    logic             e_valid [ENTRIES];
    logic [VPN_W-1:0] e_vpn   [ENTRIES];
    logic [CA_W-1:0]  e_ca    [ENTRIES];
    logic [SEGS-1:0]  e_vvec  [ENTRIES];
    logic [SEGS-1:0]  e_rvec  [ENTRIES];

    logic             look_hit;
    logic [IDX_W-1:0] look_idx;
    logic             coh_hit;
    logic [IDX_W-1:0] coh_idx;
    logic [IDX_W-1:0] victim;
    logic             seg_ok;
    logic             ins_en;
    logic             fill_en;
    logic             resolving;

    // Lookup comparator on the captured request
    fpx_cam #(.N(ENTRIES), .KEY_W(VPN_W), .IDX_W(IDX_W)) u_look (
        .valid (e_valid),
        .keys  (e_vpn),
        .key   (req_vpn_q),
        .hit   (look_hit),
        .idx   (look_idx)
    );

    // Second comparator dedicated to coherence broadcasts
    fpx_cam #(.N(ENTRIES), .KEY_W(VPN_W), .IDX_W(IDX_W)) u_coh (
        .valid (e_valid),
        .keys  (e_vpn),
        .key   (coh_vpn),
        .hit   (coh_hit),
        .idx   (coh_idx)
    );

    fpx_rr #(.N(ENTRIES), .IDX_W(IDX_W)) u_rr (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (ins_en),
        .victim (victim)
    );

    fpx_store #(
        .N(ENTRIES), .IDX_W(IDX_W), .VPN_W(VPN_W),
        .CA_W(CA_W), .SEGS(SEGS), .SEG_W(SEG_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .ins_en   (ins_en),
        .ins_idx  (victim),
        .ins_vpn  (req_vpn_q),
        .ins_ca   (walk_ca),
        .ins_vvec (walk_vvec),
        .fill_en  (fill_en),
        .fill_idx (pend_idx_q),
        .fill_seg (pend_seg_q),
        .coh_en   (coh_set && coh_hit),
        .coh_idx  (coh_idx),
        .coh_seg  (coh_seg),
        .e_valid  (e_valid),
        .e_vpn    (e_vpn),
        .e_ca     (e_ca),
        .e_vvec   (e_vvec),
        .e_rvec   (e_rvec)
    );

    assign resolving = (state_q == ST_RESOLVE);
    assign seg_ok    = e_vvec[look_idx][req_seg_q];
    assign ins_en    = (state_q == ST_WALK) && walk_ack;
    assign fill_en   = fill_done && pend_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (lk_valid) begin
                    state_d = ST_RESOLVE;              // accept
                end
            end
            ST_RESOLVE: begin
                if (look_hit && seg_ok) begin
                    state_d = ST_IDLE;                 // serve (hit)
                end else if (pend_q) begin
                    state_d = ST_STALL;                // park
                end else if (look_hit) begin
                    state_d = ST_IDLE;                 // serve (fill issued)
                end else begin
                    state_d = ST_WALK;                 // miss
                end
            end
            ST_WALK: begin
                if (walk_ack) begin
                    state_d = ST_RESOLVE;              // install
                end
            end
            ST_STALL: begin
                if (!pend_q) begin
                    state_d = ST_RESOLVE;              // retry
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        lk_ready    = (state_q == ST_IDLE);
        hit_valid   = resolving && look_hit && seg_ok;
        fill_req    = resolving && look_hit && !seg_ok && !pend_q;
        hit_addr    = {e_ca[look_idx], req_seg_q};
        fill_addr   = {e_ca[look_idx], req_seg_q};
        walk_req    = (state_q == ST_WALK);
        walk_vpn    = req_vpn_q;
        evict_valid = ins_en && e_valid[victim];
        evict_vpn   = e_vpn[victim];
        evict_vvec  = e_vvec[victim];
        evict_rvec  = e_rvec[victim];
    end

    // Request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_vpn_q <= '0;
            req_seg_q <= '0;
        end else if (lk_valid && lk_ready) begin
            req_vpn_q <= lk_line[VA_W-LINE_W-1 -: VPN_W];
            req_seg_q <= lk_line[SEG_W-1:0];
        end
    end

    // Outstanding fill tracker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= 1'b0;
            pend_idx_q <= '0;
            pend_seg_q <= '0;
        end else if (fill_req) begin
            pend_q     <= 1'b1;
            pend_idx_q <= look_idx;
            pend_seg_q <= req_seg_q;
        end else if (fill_en) begin
            pend_q     <= 1'b0;
        end
    end

endmodule

// File: rtl/fpx_chk.sv
module fpx_chk #(
    parameter int VPN_W = 23
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic             lk_ready,
    input logic             hit_valid,
    input logic             fill_req,
    input logic             walk_req,
    input logic             walk_ack,
    input logic [VPN_W-1:0] walk_vpn,
    input logic             evict_valid,
    input logic             pend_q
);

    // R2
    accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ready) |=> !lk_ready);

    // R4
    single_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hit_valid, fill_req, walk_req}));

    // R6
    no_dup_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |-> !pend_q);

    // R7
    walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && !walk_ack) |=> (walk_req && $stable(walk_vpn)));

    // R8
    evict_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evict_valid |-> (walk_ack && walk_req));

endmodule

bind fp_xlate_buf fpx_chk #(.VPN_W(VPN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_valid    (lk_valid),
    .lk_ready    (lk_ready),
    .hit_valid   (hit_valid),
    .fill_req    (fill_req),
    .walk_req    (walk_req),
    .walk_ack    (walk_ack),
    .walk_vpn    (walk_vpn),
    .evict_valid (evict_valid),
    .pend_q      (pend_q)
);

// File: tb/fp_xlate_buf_tb.sv
`timescale 1ns/1ps
module fp_xlate_buf_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [25:0] lk_line = '0;
    logic        lk_ready;
    logic        hit_valid;
    logic [18:0] hit_addr;
    logic        fill_req;
    logic [18:0] fill_addr;
    logic        fill_done = 1'b0;
    logic        walk_req;
    logic [22:0] walk_vpn;
    logic        walk_ack = 1'b0;
    logic [15:0] walk_ca = '0;
    logic [7:0]  walk_vvec = '0;
    logic        coh_set = 1'b0;
    logic [22:0] coh_vpn = '0;
    logic [2:0]  coh_seg = '0;
    logic        evict_valid;
    logic [22:0] evict_vpn;
    logic [7:0]  evict_vvec;
    logic [7:0]  evict_rvec;

    always #5 clk = ~clk;

    fp_xlate_buf u_dut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_line(lk_line),
        .lk_ready(lk_ready), .hit_valid(hit_valid), .hit_addr(hit_addr),
        .fill_req(fill_req), .fill_addr(fill_addr), .fill_done(fill_done),
        .walk_req(walk_req), .walk_vpn(walk_vpn), .walk_ack(walk_ack),
        .walk_ca(walk_ca), .walk_vvec(walk_vvec), .coh_set(coh_set),
        .coh_vpn(coh_vpn), .coh_seg(coh_seg), .evict_valid(evict_valid),
        .evict_vpn(evict_vpn), .evict_vvec(evict_vvec), .evict_rvec(evict_rvec)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // Behavioural reference state
    bit          m_used [4];
    logic [22:0] m_vpn  [4];
    logic [15:0] m_ca   [4];
    logic [7:0]  m_vv   [4];
    logic [7:0]  m_rv   [4];
    int          m_ptr = 0;
    bit          m_pend = 0;
    int          m_pidx = 0;
    int          m_pseg = 0;
    bit          exp_evict = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int mfind(input logic [22:0] vpn);
        int r = -1;
        for (int i = 0; i < 4; i++) begin
            if (m_used[i] && m_vpn[i] == vpn) r = i;
        end
        return r;
    endfunction

    // Per-clock comparison of eviction and result exclusivity
    always begin
        @(negedge clk);
        #2;
        if (rst_n) begin
            check(evict_valid == exp_evict, "R8", "evict_valid per cycle", evict_valid, exp_evict);
            check($countones({hit_valid, fill_req, walk_req}) <= 1, "R4", "one result at a time",
                  {hit_valid, fill_req, walk_req}, 0);
        end
    end

    task automatic lookup(input logic [22:0] vpn, input int seg,
                          input logic [15:0] wca, input logic [7:0] wvv);
        int  idx;
        bit  done = 0;
        @(negedge clk);
        check(lk_ready, "R2", "ready before lookup", lk_ready, 1);
        lk_valid = 1'b1;
        lk_line  = {vpn, 3'(seg)};
        @(negedge clk);
        lk_valid = 1'b0;
        check(!lk_ready, "R2", "ready low after accept", lk_ready, 0);
        for (int c = 0; c < 12 && !done; c++) begin
            idx = mfind(vpn);
            if (m_pend && (idx < 0 || !m_vv[idx][seg])) begin
                check({hit_valid, fill_req, walk_req} == 3'b000, "R6", "quiet while fill pending",
                      {hit_valid, fill_req, walk_req}, 0);
                fill_done = 1'b1;
                @(posedge clk);
                m_vv[m_pidx][m_pseg] = 1'b1;
                m_rv[m_pidx][m_pseg] = 1'b1;
                m_pend = 0;
                @(negedge clk);
                fill_done = 1'b0;
                check({hit_valid, fill_req, walk_req, lk_ready} == 4'b0000, "R6", "still stalled",
                      {hit_valid, fill_req, walk_req, lk_ready}, 0);
                @(negedge clk);
            end else if (idx < 0) begin
                check({hit_valid, fill_req, walk_req} == 3'b000, "R7", "no result on miss cycle",
                      {hit_valid, fill_req, walk_req}, 0);
                @(negedge clk);
                check(walk_req, "R7", "walk_req raised", walk_req, 1);
                check(walk_vpn == vpn, "R7", "walk_vpn", walk_vpn, vpn);
                walk_ca   = wca;
                walk_vvec = wvv;
                walk_ack  = 1'b1;
                exp_evict = m_used[m_ptr];
                #2;
                if (m_used[m_ptr]) begin
                    check(evict_vpn == m_vpn[m_ptr], "R8", "evict_vpn", evict_vpn, m_vpn[m_ptr]);
                    check(evict_vvec == m_vv[m_ptr], "R8", "evict_vvec", evict_vvec, m_vv[m_ptr]);
                    check(evict_rvec == m_rv[m_ptr], "R10", "evict_rvec", evict_rvec, m_rv[m_ptr]);
                end
                @(posedge clk);
                m_used[m_ptr] = 1;
                m_vpn[m_ptr]  = vpn;
                m_ca[m_ptr]   = wca;
                m_vv[m_ptr]   = wvv;
                m_rv[m_ptr]   = 8'h00;
                m_ptr = (m_ptr + 1) % 4;
                @(negedge clk);
                walk_ack  = 1'b0;
                exp_evict = 1'b0;
            end else if (m_vv[idx][seg]) begin
                check(hit_valid && !fill_req, "R3", "hit_valid", {hit_valid, fill_req}, 2'b10);
                check(hit_addr == {m_ca[idx], 3'(seg)}, "R3", "hit_addr", hit_addr, {m_ca[idx], 3'(seg)});
                done = 1;
            end else begin
                check(fill_req && !hit_valid, "R4", "fill_req", {fill_req, hit_valid}, 2'b10);
                check(fill_addr == {m_ca[idx], 3'(seg)}, "R4", "fill_addr", fill_addr, {m_ca[idx], 3'(seg)});
                m_pend = 1;
                m_pidx = idx;
                m_pseg = seg;
                done = 1;
            end
        end
        check(done, "R2", "lookup resolved", done, 1);
        @(negedge clk);
        check(lk_ready && !fill_req && !hit_valid, "R2", "ready after result",
              {lk_ready, fill_req, hit_valid}, 3'b100);
    endtask

    task automatic pulse_fill_done();
        @(negedge clk);
        fill_done = 1'b1;
        @(posedge clk);
        if (m_pend) begin
            m_vv[m_pidx][m_pseg] = 1'b1;
            m_rv[m_pidx][m_pseg] = 1'b1;
            m_pend = 0;
        end
        @(negedge clk);
        fill_done = 1'b0;
    endtask

    task automatic coherence(input logic [22:0] vpn, input int seg);
        int idx;
        @(negedge clk);
        coh_set = 1'b1;
        coh_vpn = vpn;
        coh_seg = 3'(seg);
        @(posedge clk);
        idx = mfind(vpn);
        if (idx >= 0) m_vv[idx][seg] = 1'b1;
        @(negedge clk);
        coh_set = 1'b0;
    endtask

    localparam logic [22:0] P0 = 23'h000100;
    localparam logic [22:0] P1 = 23'h000201;
    localparam logic [22:0] P2 = 23'h000302;
    localparam logic [22:0] P3 = 23'h000403;
    localparam logic [22:0] P4 = 23'h000504;
    localparam logic [22:0] P5 = 23'h000605;
    localparam logic [22:0] PX = 23'h7ff001;

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_used[i] = 0; m_vpn[i] = '0; m_ca[i] = '0; m_vv[i] = '0; m_rv[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(lk_ready, "R1", "lk_ready after reset", lk_ready, 1);
        check({hit_valid, fill_req, walk_req, evict_valid} == 4'b0000, "R1", "outputs idle after reset",
              {hit_valid, fill_req, walk_req, evict_valid}, 0);

        // R11: stray walker acknowledge in idle installs nothing
        walk_ack = 1'b1; walk_ca = 16'hdead; walk_vvec = 8'hff;
        @(negedge clk);
        walk_ack = 1'b0;
        check(lk_ready, "R11", "stray walk_ack leaves block idle", lk_ready, 1);

        // R1, R7, R3: first lookup misses, walker installs, then hit
        lookup(P0, 2, 16'h0011, 8'h05);

        // R11: stray fill completion sets nothing; seg 7 still needs a fill (R4)
        pulse_fill_done();
        lookup(P0, 7, 16'h0, 8'h0);
        // R5: completion makes the segment hit
        pulse_fill_done();
        lookup(P0, 7, 16'h0, 8'h0);

        // R6: repeat lookup to an unfilled segment stalls, then hits
        lookup(P0, 3, 16'h0, 8'h0);
        lookup(P0, 3, 16'h0, 8'h0);

        // R6: a miss while a fill is outstanding stalls before walking
        lookup(P0, 4, 16'h0, 8'h0);
        lookup(P1, 0, 16'h0022, 8'h80);
        pulse_fill_done();

        // R9: broadcast to resident page turns segment valid
        coherence(P0, 6);
        lookup(P0, 6, 16'h0, 8'h0);
        // R9: broadcast to absent page has no effect
        coherence(PX, 1);
        lookup(P1, 1, 16'h0, 8'h0);
        pulse_fill_done();

        // R8: fill all slots, then round-robin eviction with vectors (R10 on rvec)
        lookup(P2, 0, 16'h0033, 8'h01);
        lookup(P3, 5, 16'h0044, 8'h20);
        lookup(P4, 0, 16'h0055, 8'hff);
        lookup(P5, 1, 16'h0066, 8'h02);
        // R8: evicted page misses again and replaces slot 2
        lookup(P0, 2, 16'h0077, 8'h04);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule